// File: doc/BRIEF.md
# Descriptor-End Condition Evaluator

This block settles what a descriptor-driven DMA channel does when a descriptor ends. It makes three decisions: whether to raise the channel interrupt, whether to stall the channel, and whether the next command pointer comes from the descriptor's dependent-address word or moves past the current descriptor. Each decision has its own 2-bit mode in the command word and its own select register. A select register holds a mask and a compare value, and these are tested against the device-status nibble.

The channel sequencer pulses `end_valid` together with the command word, the device status, the three selects and the dependent address. One clock later the block reports the outcome on `res_valid`, `res_wait` and `res_branch`. In that same cycle it updates the command pointer, the branch-taken status bit and the interrupt level. Software loads the pointer through `ptr_set` and acknowledges the interrupt with `irq_clr`.

Top module: `dsc_end_eval`

## Requirements
- R1: Each select input carries its mask in bits 19:16 and its compare value in bits 3:0. The condition holds when (dev_status AND mask) equals (value AND mask). All other bits have no effect.
- R2: The command field holds the wait mode in bits 1:0, the branch mode in bits 3:2 and the interrupt mode in bits 5:4. The mode encodings are 00 never, 01 when the condition holds, 10 when it does not hold, and 11 always.
- R3: The outcome of an `end_valid` cycle appears one clock later as a one-cycle `res_valid` pulse with `res_wait` and `res_branch`. The pointer, `branch_taken` and `irq` update at that same edge.
- R4: When the wait decision fires, the interrupt is not raised, no branch is reported, and `cmd_ptr` and `branch_taken` keep their values.
- R5: A branch that fires, with no wait, loads `cmd_ptr` with `dep_addr` and sets `branch_taken`.
- R6: An end with no wait and no branch adds 16 to `cmd_ptr` and clears `branch_taken`.
- R7: When `word_op` is high, the block never branches and always advances by 16 unless it waits. The interrupt decision still applies.
- R8: `irq` is a level. It is set by a firing interrupt decision and stays set until `irq_clr`. A set and a clear in the same cycle leave it set.
- R9: `ptr_set` loads `cmd_ptr` from `ptr_set_val` with bits 3:0 forced to zero and leaves `branch_taken` unchanged. It is ignored in a cycle where `end_valid` is high.
- R10: After reset `cmd_ptr` is 0 and `branch_taken`, `irq` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| end_valid | input | 1 | Descriptor end event |
| word_op | input | 1 | Ending descriptor is a word load/store |
| cond_field | input | 6 | Interrupt, branch and wait modes |
| dev_status | input | 4 | Device-status nibble |
| irq_sel | input | 32 | Interrupt mask/value select |
| branch_sel | input | 32 | Branch mask/value select |
| wait_sel | input | 32 | Wait mask/value select |
| dep_addr | input | ADDR_W | Branch target from the descriptor |
| ptr_set | input | 1 | Load the command pointer |
| ptr_set_val | input | ADDR_W | Value for the pointer load |
| irq_clr | input | 1 | Clear the interrupt level |
| res_valid | output | 1 | Outcome valid pulse |
| res_wait | output | 1 | Channel stalls |
| res_branch | output | 1 | Branch taken |
| cmd_ptr | output | ADDR_W | Command pointer |
| branch_taken | output | 1 | Branch-taken status bit |
| irq | output | 1 | Interrupt level |

## Verification
The hardest situations to reach are collisions between sources: an interrupt raised in the same cycle as `irq_clr`, a pointer load that lands on an end event, and a wait that fires while the branch and interrupt modes are set to always. The stimulus drives these coincidences on purpose. It also uses partial masks, where status bits outside the mask disagree with the value, so that a comparison that ignores the mask gives a visibly different result.

// File: rtl/dsc_eval_pkg.sv
package dsc_eval_pkg;

  typedef enum logic [1:0] {
    CM_NEVER  = 2'b00,
    CM_IFSET  = 2'b01,
    CM_IFCLR  = 2'b10,
    CM_ALWAYS = 2'b11
  } cond_mode_e;

  // Order follows the field positions: decision d uses cond_field[2d+1:2d].
  localparam int ACT_WAIT = 0;
  localparam int ACT_BR   = 1;
  localparam int ACT_IRQ  = 2;
  localparam int N_ACT    = 3;

  localparam int STAT_W   = 4;
  localparam int SEL_W    = 32;
  localparam int MASK_LSB = 16;
  localparam int VAL_LSB  = 0;

  function automatic logic sel_match(input logic [STAT_W-1:0] mask,
                                     input logic [STAT_W-1:0] val,
                                     input logic [STAT_W-1:0] stat);
    return (stat & mask) == (val & mask);
  endfunction

  function automatic logic mode_fire(input cond_mode_e m, input logic hit);
    logic f;
    case (m)
      CM_NEVER:  f = 1'b0;
      CM_IFSET:  f = hit;
      CM_IFCLR:  f = !hit;
      default:   f = 1'b1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/dsc_cond_unit.sv
module dsc_cond_unit
  import dsc_eval_pkg::*;
(
  input  logic [1:0]        mode_bits,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] val,
  input  logic [STAT_W-1:0] stat,
  output logic              hit,
  output logic              fire
);
  cond_mode_e mode;

  always_comb begin
    mode = cond_mode_e'(mode_bits);
    hit  = sel_match(mask, val, stat);
    fire = mode_fire(mode, hit);
  end
endmodule

// File: rtl/dsc_ptr_unit.sv
module dsc_ptr_unit #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              take_en,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_val,
  input  logic [ADDR_W-1:0] dep,
  output logic [ADDR_W-1:0] ptr,
  output logic              bt
);
  localparam int ALIGN_W = $clog2(DESC_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      bt  <= 1'b0;
    end else if (take_en) begin
      ptr <= dep;
      bt  <= 1'b1;
    end else if (step_en) begin
      ptr <= ptr + STEP;
      bt  <= 1'b0;
    end else if (set_en) begin
      ptr <= set_val & ALIGN_MASK;
    end
  end
endmodule

// File: rtl/dsc_irq_unit.sv
module dsc_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (clr)   irq <= 1'b0;
  end
endmodule

// File: rtl/dsc_end_eval.sv
module dsc_end_eval
  import dsc_eval_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_valid,
  input  logic              word_op,
  input  logic [5:0]        cond_field,
  input  logic [3:0]        dev_status,
  input  logic [31:0]       irq_sel,
  input  logic [31:0]       branch_sel,
  input  logic [31:0]       wait_sel,
  input  logic [ADDR_W-1:0] dep_addr,
  input  logic              ptr_set,
  input  logic [ADDR_W-1:0] ptr_set_val,
  input  logic              irq_clr,
  output logic              res_valid,
  output logic              res_wait,
  output logic              res_branch,
  output logic [ADDR_W-1:0] cmd_ptr,
  output logic              branch_taken,
  output logic              irq
);
  logic [SEL_W-1:0] sel_arr [N_ACT];
  logic [N_ACT-1:0] act_hit;
  logic [N_ACT-1:0] act_fire;

  // Named internal events for the checker.
  logic ev_wait, ev_go, ev_take, ev_step, ev_raise, ev_set;

  assign sel_arr[ACT_WAIT] = wait_sel;
  assign sel_arr[ACT_BR]   = branch_sel;
  assign sel_arr[ACT_IRQ]  = irq_sel;

  for (genvar g = 0; g < N_ACT; g++) begin : g_cond
    dsc_cond_unit u_cond (
      .mode_bits (cond_field[2*g +: 2]),
      .mask      (sel_arr[g][MASK_LSB +: STAT_W]),
      .val       (sel_arr[g][VAL_LSB +: STAT_W]),
      .stat      (dev_status),
      .hit       (act_hit[g]),
      .fire      (act_fire[g])
    );
  end

  wire sel_spare_unused = ^{act_hit,
                            irq_sel[31:20], irq_sel[15:4],
                            branch_sel[31:20], branch_sel[15:4],
                            wait_sel[31:20], wait_sel[15:4]};

  always_comb begin
    ev_wait  = end_valid && act_fire[ACT_WAIT];
    ev_go    = end_valid && !act_fire[ACT_WAIT];
    ev_take  = ev_go && !word_op && act_fire[ACT_BR];
    ev_step  = ev_go && !ev_take;
    ev_raise = ev_go && act_fire[ACT_IRQ];
    ev_set   = ptr_set && !end_valid;
  end

  dsc_ptr_unit #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (ev_step),
    .take_en (ev_take),
    .set_en  (ev_set),
    .set_val (ptr_set_val),
    .dep     (dep_addr),
    .ptr     (cmd_ptr),
    .bt      (branch_taken)
  );

  dsc_irq_unit u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (ev_raise),
    .clr   (irq_clr),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_wait   <= 1'b0;
      res_branch <= 1'b0;
    end else begin
      res_valid  <= end_valid;
      res_wait   <= ev_wait;
      res_branch <= ev_take;
    end
  end
endmodule

// File: rtl/dsc_end_eval_chk.sv
module dsc_end_eval_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              end_valid,
  input logic              word_op,
  input logic [5:0]        cond_field,
  input logic [ADDR_W-1:0] dep_addr,
  input logic              irq_clr,
  input logic              res_valid,
  input logic              res_wait,
  input logic              res_branch,
  input logic [ADDR_W-1:0] cmd_ptr,
  input logic              branch_taken,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(16);

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |=> res_valid);

  p_wait_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && cond_field[1:0] == 2'b11) |=> res_wait);

  p_wait_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wait) |-> (!res_branch && cmd_ptr == $past(cmd_ptr)
                                 && branch_taken == $past(branch_taken)));

  p_branch_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_branch) |-> (branch_taken && cmd_ptr == $past(dep_addr)));

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_wait && !res_branch) |->
      (!branch_taken && cmd_ptr == $past(cmd_ptr) + STEP));

  p_word_no_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && word_op) |=> !res_branch);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind dsc_end_eval dsc_end_eval_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .end_valid    (end_valid),
  .word_op      (word_op),
  .cond_field   (cond_field),
  .dep_addr     (dep_addr),
  .irq_clr      (irq_clr),
  .res_valid    (res_valid),
  .res_wait     (res_wait),
  .res_branch   (res_branch),
  .cmd_ptr      (cmd_ptr),
  .branch_taken (branch_taken),
  .irq          (irq)
);

// File: tb/dsc_end_eval_test.sv
module dsc_end_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        end_valid = 1'b0;
  logic        word_op = 1'b0;
  logic [5:0]  cond_field = '0;
  logic [3:0]  dev_status = '0;
  logic [31:0] irq_sel = '0, branch_sel = '0, wait_sel = '0;
  logic [31:0] dep_addr = '0;
  logic        ptr_set = 1'b0;
  logic [31:0] ptr_set_val = '0;
  logic        irq_clr = 1'b0;
  logic        res_valid, res_wait, res_branch, branch_taken, irq;
  logic [31:0] cmd_ptr;

  always #2 clk = ~clk;

  dsc_end_eval uut (.*);

  typedef struct {
    string tag;
    bit w; bit b; bit [31:0] p; bit t; bit q;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  bit [31:0]   m_ptr = 0;
  bit          m_bt = 0, m_irq = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic bit cond_ok(bit [31:0] sel, bit [3:0] st);
    return ((st ^ sel[3:0]) & sel[19:16]) == 4'b0;
  endfunction

  function automatic bit decide(bit [1:0] m, bit c);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b11) return 1'b1;
    return (m == 2'b01) ? c : !c;
  endfunction

  // Driver: one end event, expected outcome pushed to the scoreboard.
  task automatic ev(input string tag, input bit wop, input bit [5:0] f,
                    input bit [3:0] st, input bit [31:0] is, input bit [31:0] bs,
                    input bit [31:0] ws, input bit [31:0] dep,
                    input bit clr, input bit pset);
    exp_t e;
    bit w, b, q;
    w = decide(f[1:0], cond_ok(ws, st));
    b = !w && !wop && decide(f[3:2], cond_ok(bs, st));
    q = !w && decide(f[5:4], cond_ok(is, st));
    if (!w) begin
      if (b) begin m_ptr = dep; m_bt = 1; end
      else   begin m_ptr = m_ptr + 32'd16; m_bt = 0; end
    end
    if (q) m_irq = 1;
    else if (clr) m_irq = 0;
    e.tag = tag; e.w = w; e.b = b; e.p = m_ptr; e.t = m_bt; e.q = m_irq;
    sb.push_back(e);
    end_valid = 1; word_op = wop; cond_field = f; dev_status = st;
    irq_sel = is; branch_sel = bs; wait_sel = ws; dep_addr = dep;
    irq_clr = clr; ptr_set = pset; ptr_set_val = 32'hDEAD_BEE0;
    @(negedge clk);
    end_valid = 0; irq_clr = 0; ptr_set = 0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t e;
      if (sb.size() == 0) chk(0, "R3", "unexpected res_valid", 1, 0);
      else begin
        e = sb.pop_front();
        chk(res_wait == e.w, e.tag, "res_wait", res_wait, e.w);
        chk(res_branch == e.b, e.tag, "res_branch", res_branch, e.b);
        chk(cmd_ptr == e.p, e.tag, "cmd_ptr", cmd_ptr, e.p);
        chk(branch_taken == e.t, e.tag, "branch_taken", branch_taken, e.t);
        chk(irq == e.q, e.tag, "irq", irq, e.q);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cmd_ptr == 0, "R10", "cmd_ptr", cmd_ptr, 0);
    chk(!branch_taken && !irq && !res_valid, "R10", "flags",
        {branch_taken, irq, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 pointer load with alignment
    ptr_set = 1; ptr_set_val = 32'h1000_0005;
    @(negedge clk); ptr_set = 0;
    m_ptr = 32'h1000_0000;
    chk(cmd_ptr == m_ptr, "R9", "aligned load", cmd_ptr, m_ptr);
    chk(!res_valid, "R3", "no result without end", res_valid, 0);

    // R6 all never: advance
    ev("R6", 0, 6'b00_00_00, 4'h0, 0, 0, 0, 32'h2000_0040, 0, 0);
    // R5 branch always
    ev("R5", 0, 6'b00_11_00, 4'h0, 0, 0, 0, 32'h2000_0040, 0, 0);
    // R1 full mask match, branch if-set
    ev("R1", 0, 6'b00_01_00, 4'h5, 0, 32'h000F_0005, 0, 32'h3000_0000, 0, 0);
    // R1 mismatch -> advance, BT clears (R6)
    ev("R1", 0, 6'b00_01_00, 4'h4, 0, 32'h000F_0005, 0, 32'h3100_0000, 0, 0);
    // R1 partial mask, spare bits set: match, so if-clear does not branch
    ev("R1", 0, 6'b00_10_00, 4'hD, 0, 32'hFFF3_FFF1, 0, 32'h3200_0000, 0, 0);
    // R2 if-clear with mismatch branches
    ev("R2", 0, 6'b00_10_00, 4'hC, 0, 32'h0003_0001, 0, 32'h3300_0000, 0, 0);
    // R4 wait always overrides branch and irq always
    ev("R4", 0, 6'b11_11_11, 4'h0, 0, 0, 0, 32'h4000_0000, 0, 0);
    // R2 wait if-set match; wait if-clear with match does not wait
    ev("R2", 0, 6'b00_00_01, 4'h8, 0, 0, 32'h0008_0008, 32'h0, 0, 0);
    ev("R2", 0, 6'b00_00_10, 4'h8, 0, 0, 32'h0008_0008, 32'h0, 0, 0);
    // R8 irq if-set
    ev("R8", 0, 6'b01_00_00, 4'h2, 32'h0002_0002, 0, 0, 32'h0, 0, 0);
    chk(irq == 1, "R8", "irq held", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0;
    chk(irq == 0, "R8", "irq cleared", irq, 0);
    // R8 raise and clear together: stays set
    ev("R8", 0, 6'b11_00_00, 4'h0, 0, 0, 0, 32'h0, 1, 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0;
    // R7 word op never branches, interrupt still fires
    ev("R7", 1, 6'b11_11_00, 4'h0, 0, 0, 0, 32'h5000_0000, 0, 0);
    // R9 pointer load colliding with end is ignored
    ev("R9", 0, 6'b00_00_00, 4'h0, 0, 0, 0, 32'h0, 0, 1);
    // R4 wait with irq if-set match: irq stays low
    irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0;
    ev("R4", 0, 6'b01_00_11, 4'h1, 32'h0001_0001, 0, 0, 32'h0, 0, 0);
    chk(irq == 0, "R4", "irq after wait", irq, 0);
    // back-to-back ends: R3
    ev("R3", 0, 6'b00_11_00, 4'h0, 0, 0, 0, 32'h6000_0100, 0, 0);
    ev("R3", 0, 6'b00_00_00, 4'h0, 0, 0, 0, 32'h0, 0, 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule